// File: doc/BRIEF.md
# Halfword Instruction Stream Assembler

This block sits between an instruction fetch path and a decoder. It receives 16-bit halfwords in program order, one per handshake. From these it builds whole instructions. An instruction is either one halfword or two consecutive halfwords. The five most significant bits of a leading halfword decide which. The decoder receives a 32-bit instruction word, a flag that marks a 32-bit instruction, and the byte address of the instruction's first halfword.

A two-state machine controls the assembly. In `ST_EMPTY` nothing is held. A leading halfword that carries a wide prefix takes the transition `GRAB_FIRST` into `ST_HALF`. Any other leading halfword takes `EMIT_NARROW`, stays in `ST_EMPTY` and is presented at once. In `ST_HALF` the next accepted halfword completes the pair. The machine then takes `EMIT_WIDE` back to `ST_EMPTY`. A flush takes `FLUSH_DROP` from either state into `ST_EMPTY`. In the same cycle it reloads the running address. Idle cycles keep the current state.

The output register follows the usual valid/ready rule. An instruction that has not been taken stays unchanged. While it waits, no new halfword is accepted.

Top module: `halfword_instr_assembler`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and no halfword is held.
- R2: A leading halfword whose bits [15:11] are not 11101, 11110 or 11111 is output alone: `out_wide`=0, `out_instr[15:0]` is the halfword and `out_instr[31:16]` is 0. It appears in the cycle after it is accepted.
- R3: A leading halfword whose bits [15:11] are 11101, 11110 or 11111 is held. The next accepted halfword completes it: `out_wide`=1, first halfword in `out_instr[31:16]`, second in `out_instr[15:0]`. It appears in the cycle after the second halfword is accepted.
- R4: `out_addr` is the byte address of the instruction's first halfword. The running address grows by 2 for each accepted halfword, and its bit 0 is always 0.
- R5: While a first halfword is held, `out_valid` stays 0 through any number of cycles without input, and the held halfword is kept.
- R6: A `flush` drops any held halfword and returns to `ST_EMPTY`. In the same cycle it loads `flush_addr` with bit 0 forced to 0 as the next address. `in_ready` is 0 during `flush`, so any halfword offered in that cycle is dropped.
- R7: While `out_valid`=1 and `out_ready`=0, `out_instr`, `out_wide` and `out_addr` stay stable and `in_ready` is 0.
- R8: Without a flush, the first instruction after reset has the address `RESET_ADDR` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop held halfword and reload address |
| flush_addr | input | ADDR_W | New start byte address (bit 0 ignored) |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword can be taken |
| in_half | input | 16 | Halfword in program order |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Consumer takes instruction |
| out_instr | output | 32 | Assembled instruction word |
| out_wide | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| out_addr | output | ADDR_W | Byte address of the first halfword |

## Verification
The main stimulus sweeps all 32 values of the five-bit prefix. Each value is given its own payload bits, so each prefix shows on its own whether it is classed as wide or narrow. The sweep also exposes any swap of the two halves or a wrong address step.

The sweep runs twice: once with the consumer always ready, and once with pseudo-random back-pressure. The second pass separates proper stall holding from output that moves or input that is taken while the consumer is blocked.

Three further patterns cover the remaining cases. A held first half followed by a long idle gap shows whether the held state persists. A flush in the middle of a pair, with a halfword offered in the flush cycle and an odd flush address, shows whether the held half is dropped, whether the offered halfword is dropped and whether bit 0 is forced to 0. The first instruction after reset checks the reset address.

// File: rtl/hwa_pkg.sv
package hwa_pkg;
    localparam int HALF_W     = 16;
    localparam int INSTR_W    = 2 * HALF_W;
    localparam int PFX_W      = 5;
    localparam int N_WIDE_PFX = 3;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HALF  = 1'b1
    } asm_state_t;

    // Wide prefixes are the three consecutive codes starting at 5'b11101.
    function automatic logic [PFX_W-1:0] wide_pfx(input int idx);
        return 5'b11101 + PFX_W'(idx);
    endfunction
endpackage

// File: rtl/hwa_len_detect.sv
module hwa_len_detect
    import hwa_pkg::*;
(
    input  logic [PFX_W-1:0] pfx_i,
    output logic             wide_o
);
    logic [N_WIDE_PFX-1:0] hit;

    generate
        for (genvar g = 0; g < N_WIDE_PFX; g++) begin : g_pfx
            assign hit[g] = (pfx_i == wide_pfx(g));
        end
    endgenerate

    assign wide_o = |hit;

    // R3
    always_comb begin
        wide_class_chk: assert (wide_o == ((pfx_i[4:2] == 3'b111) && (pfx_i[1:0] != 2'b00)));
    end
endmodule

// File: rtl/hwa_addr_track.sv
module hwa_addr_track #(
    parameter int unsigned          ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]    RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic              step_i,
    input  logic              capture_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] lead_addr_o
);
    localparam logic [ADDR_W-1:0] HALF_BYTES = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] lead_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= RESET_ADDR & ALIGN_MASK;
        end else if (flush_i) begin
            cur_q <= flush_addr_i & ALIGN_MASK;
        end else if (step_i) begin
            cur_q <= cur_q + HALF_BYTES;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
        end else if (capture_i && !flush_i) begin
            lead_q <= cur_q;
        end
    end

    assign cur_addr_o  = cur_q;
    assign lead_addr_o = lead_q;

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !flush_i) |=> (cur_q == $past(cur_q) + HALF_BYTES));

    // R4
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[0] == 1'b0) && (lead_q[0] == 1'b0));

    // R6
    flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cur_q == ($past(flush_addr_i) & ALIGN_MASK)));
endmodule

// File: rtl/hwa_out_reg.sv
module hwa_out_reg #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               wide_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic               wide_o,
    output logic [ADDR_W-1:0]  addr_o
);
    logic               valid_q;
    logic [INSTR_W-1:0] instr_q;
    logic               wide_q;
    logic [ADDR_W-1:0]  addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
        end else if (load_i) begin
            instr_q <= instr_i;
            wide_q  <= wide_i;
            addr_q  <= addr_i;
        end
    end

    assign valid_o = valid_q;
    assign instr_o = instr_q;
    assign wide_o  = wide_q;
    assign addr_o  = addr_q;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |=> (valid_q && $stable(instr_q) && $stable(wide_q) && $stable(addr_q)));

    // R7
    stall_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |-> !load_i);
endmodule

// File: rtl/halfword_instr_assembler.sv
module halfword_instr_assembler
    import hwa_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [ADDR_W-1:0]  flush_addr,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [HALF_W-1:0]  in_half,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic               out_wide,
    output logic [ADDR_W-1:0]  out_addr
);
    asm_state_t         state_q, state_d;
    logic [HALF_W-1:0]  held_q;
    logic               accept;
    logic               is_wide;
    logic               capture;
    logic               emit;
    logic [INSTR_W-1:0] emit_instr;
    logic               emit_wide;
    logic [ADDR_W-1:0]  emit_addr;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  lead_addr;

    assign in_ready = !flush && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    hwa_len_detect i_len (
        .pfx_i  (in_half[HALF_W-1 -: PFX_W]),
        .wide_o (is_wide)
    );

    hwa_addr_track #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) i_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .flush_addr_i (flush_addr),
        .step_i       (accept),
        .capture_i    (capture),
        .cur_addr_o   (cur_addr),
        .lead_addr_o  (lead_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                held_q <= in_half;
            end
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d    = state_q;
        capture    = 1'b0;
        emit       = 1'b0;
        emit_instr = '0;
        emit_wide  = 1'b0;
        emit_addr  = cur_addr;
        if (flush) begin
            state_d = ST_EMPTY;                       // FLUSH_DROP
        end else if (accept) begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (is_wide) begin
                        capture = 1'b1;               // GRAB_FIRST
                        state_d = ST_HALF;
                    end else begin
                        emit       = 1'b1;            // EMIT_NARROW
                        emit_instr = {{HALF_W{1'b0}}, in_half};
                    end
                end
                ST_HALF: begin
                    emit       = 1'b1;                // EMIT_WIDE
                    emit_wide  = 1'b1;
                    emit_instr = {held_q, in_half};
                    emit_addr  = lead_addr;
                    state_d    = ST_EMPTY;
                end
            endcase
        end
    end

    hwa_out_reg #(
        .INSTR_W (INSTR_W),
        .ADDR_W  (ADDR_W)
    ) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .instr_i (emit_instr),
        .wide_i  (emit_wide),
        .addr_i  (emit_addr),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .instr_o (out_instr),
        .wide_o  (out_wide),
        .addr_o  (out_addr)
    );

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_instr[INSTR_W-1:HALF_W] == '0));

    // R5
    held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALF && !in_valid && !flush) |=> (state_q == ST_HALF && $stable(held_q)));

    // R6
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == ST_EMPTY));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_halfword_instr_assembler.sv
module test_halfword_instr_assembler;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_half = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [31:0]   out_instr;
    logic          out_wide;
    logic [AW-1:0] out_addr;

    int checks = 0;
    int fails  = 0;

    logic [31:0]   e_instr [0:511];
    logic          e_wide  [0:511];
    logic [AW-1:0] e_addr  [0:511];
    int wr = 0;
    int rd = 0;
    logic [AW-1:0] pc = '0;

    logic        bp_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    logic          prev_stall = 1'b0;
    logic [31:0]   p_instr;
    logic          p_wide;
    logic [AW-1:0] p_addr;

    halfword_instr_assembler #(.ADDR_W(AW)) i_halfword_instr_assembler (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_half(in_half),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .out_wide(out_wide), .out_addr(out_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Consumer ready pattern
    always @(negedge clk) begin
        if (bp_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[3];
        end else begin
            out_ready = 1'b1;
        end
    end

    // Output monitor, samples 1 ns before each rising edge
    always begin
        @(negedge clk);
        #4;
        if (rst_n) begin
            if (prev_stall) begin
                // R7
                check(out_valid == 1'b1, "R7 valid held", 64'(out_valid), 64'd1);
                check(out_instr == p_instr && out_wide == p_wide && out_addr == p_addr,
                      "R7 data held", 64'(out_instr), 64'(p_instr));
            end
            if (out_valid && !out_ready) begin
                // R7
                check(in_ready == 1'b0, "R7 input blocked", 64'(in_ready), 64'd0);
            end
            if (out_valid && out_ready) begin
                if (rd >= wr) begin
                    check(1'b0, "R5 unexpected output", 64'(out_instr), 64'd0);
                end else begin
                    check(out_instr == e_instr[rd] && out_wide == e_wide[rd],
                          e_wide[rd] ? "R3 wide word" : "R2 narrow word",
                          {31'd0, out_wide, out_instr}, {31'd0, e_wide[rd], e_instr[rd]});
                    // R4
                    check(out_addr == e_addr[rd], "R4 address", 64'(out_addr), 64'(e_addr[rd]));
                    rd++;
                end
            end
            prev_stall = out_valid && !out_ready;
            p_instr = out_instr;
            p_wide  = out_wide;
            p_addr  = out_addr;
        end
    end

    task automatic send_half(input logic [15:0] h, input bit last,
                             input logic [31:0] ei, input bit ew, input logic [AW-1:0] ea);
        @(negedge clk);
        in_valid = 1'b1;
        in_half  = h;
        #4;
        while (!in_ready) begin
            @(negedge clk);
            #4;
        end
        if (last) begin
            e_instr[wr] = ei;
            e_wide[wr]  = ew;
            e_addr[wr]  = ea;
            wr++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_narrow(input logic [15:0] h);
        send_half(h, 1'b1, {16'h0, h}, 1'b0, pc);
        pc = pc + 2;
    endtask

    task automatic send_wide(input logic [15:0] h1, input logic [15:0] h2);
        logic [AW-1:0] a;
        a = pc;
        send_half(h1, 1'b0, '0, 1'b0, '0);
        pc = pc + 2;
        send_half(h2, 1'b1, {h1, h2}, 1'b1, a);
        pc = pc + 2;
    endtask

    task automatic do_flush(input logic [AW-1:0] fa);
        @(negedge clk);
        flush      = 1'b1;
        flush_addr = fa;
        in_valid   = 1'b1;
        in_half    = 16'hF800;
        #4;
        // R6
        check(in_ready == 1'b0, "R6 in_ready during flush", 64'(in_ready), 64'd0);
        @(negedge clk);
        flush    = 1'b0;
        in_valid = 1'b0;
        pc = fa & ~AW'(1);
    endtask

    task automatic sweep();
        for (int p = 0; p < 32; p++) begin
            logic [15:0] h1;
            logic [15:0] h2;
            h1 = {5'(p), 11'(p * 37 + 5)};
            h2 = 16'(p * 911) ^ 16'h5A5A;
            if (p == 29 || p == 30 || p == 31) send_wide(h1, h2);
            else send_narrow(h1);
        end
        idle(1);
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && rd < wr; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R1
        check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);

        // R8: first instruction uses the reset address 0
        pc = '0;
        send_narrow(16'h4321);
        idle(1);
        drain();

        // R2 R3 R4: prefix sweep, consumer always ready
        do_flush(32'h0000_0100);
        sweep();
        drain();

        // R7: same sweep under back-pressure
        bp_mode = 1'b1;
        sweep();
        for (int i = 0; i < 200 && rd < wr; i++) @(negedge clk);
        bp_mode = 1'b0;
        drain();

        // R5: held first half across a long idle gap
        send_half(16'hE812, 1'b0, '0, 1'b0, '0);
        pc = pc + 2;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            #4;
            if (i >= 2) check(out_valid == 1'b0, "R5 no output while held", 64'(out_valid), 64'd0);
        end
        send_half(16'h3C3C, 1'b1, {16'hE812, 16'h3C3C}, 1'b1, pc - 2);
        pc = pc + 2;
        idle(1);
        drain();

        // R6: flush in the middle of a pair, odd flush address
        send_half(16'hF0AA, 1'b0, '0, 1'b0, '0);
        do_flush(32'h0000_2001);
        send_narrow(16'h1234);
        send_narrow(16'h0777);
        idle(1);
        drain();

        idle(3);
        // all queued instructions must have appeared (R6 no extra from flush)
        check(rd == wr, "R6 output count", 64'(rd), 64'(wr));
        summary();
    end
endmodule